// File: doc/BRIEF.md
# Multi-Channel Level and Edge Trigger Matcher

This block decides, sample by sample, whether a logic-analyzer capture should trigger. Software loads a small bank of byte-wide condition registers: one byte per group of four channels, each channel owning a 2-bit level condition, plus one byte that names a single channel and an edge type. Each valid sample word is compared against every enabled condition. A registered hit pulse is raised when all of them hold at once.

The edge condition compares the present sample with the last valid sample seen since arming. The first sample after reset or after an `arm_i` pulse therefore cannot satisfy an edge. With every condition cleared, the matcher triggers on any valid sample.

Top module: `trig_matcher`

## Requirements
- R1: After reset, hit_o is low and every condition register reads as zero, so no condition is enabled.
- R2: Channel n's 2-bit code sits in level byte n/4 (config address n/4) at bits 2*(n mod 4)+1 down to 2*(n mod 4). Code 1 is satisfied when the channel is 1.
- R3: Code 2 is satisfied when the channel is 0.
- R4: Codes 0 and 3 are don't-care. With all codes and the edge byte zero, every valid sample produces a hit.
- R5: The edge byte sits at config address NUM_CH/4 (8 by default). Its bits 7:6 select the edge type: 0 none, 1 rising (previous 0, current 1), 2 falling, 3 either. Bits 5:0 give the channel index. "Previous" means the last valid sample.
- R6: An enabled edge condition is never satisfied on the first valid sample after reset or after arm_i.
- R7: An edge channel index at or above NUM_CH is never satisfied.
- R8: hit_o is high in the cycle after a valid sample that meets all conditions. It is low after a cycle without sample_valid_i.
- R9: Writes to config addresses above the edge byte change no condition.
- R10: A sample presented in the same cycle as arm_i produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config byte write strobe |
| cfg_addr_i | input | ADDR_W | Config byte index |
| cfg_wdata_i | input | 8 | Config byte data |
| arm_i | input | 1 | Restart edge history |
| sample_valid_i | input | 1 | Sample word is valid |
| sample_i | input | NUM_CH | Sample word |
| hit_o | output | 1 | Registered trigger pulse |

## Verification
The bench uses the defaults: NUM_CH = 32 and a 4-bit address. This makes all eight level bytes reachable, including the top-byte channel 31. It also leaves unused addresses 9 to 15 for the decode test. Because the 6-bit edge index field can name channels 32 to 63, the unsatisfiable out-of-range edge is tested at the ports. A vector table carries one configuration through a chain of samples, so edge history, level codes and the don't-care code interact within a single armed run.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
  typedef enum logic [1:0] {
    COND_ANY  = 2'd0,
    COND_HIGH = 2'd1,
    COND_LOW  = 2'd2,
    COND_ANY3 = 2'd3
  } cond_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int unsigned EDGE_IDX_W = 6;
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  output logic [NUM_BYTES*8-1:0] lvl_o,
  output logic [7:0]             edge_o
);
  logic [NUM_BYTES*8-1:0] lvl_q;
  logic [7:0]             edge_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[b*8 +: 8] <= '0;
      else if (we_i && addr_i == ADDR_W'(b)) lvl_q[b*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= '0;
    else if (we_i && addr_i == ADDR_W'(NUM_BYTES)) edge_q <= wdata_i;
  end

  assign lvl_o  = lvl_q;
  assign edge_o = edge_q;

  // R9
  unused_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > ADDR_W'(NUM_BYTES)) |=> ($stable(lvl_q) && $stable(edge_q)));
endmodule

// File: rtl/trig_level_match.sv
module trig_level_match
  import trig_match_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic [2*NUM_CH-1:0] lvl_i,
  input  logic [NUM_CH-1:0]   sample_i,
  output logic                match_o
);
  logic [NUM_CH-1:0] ok;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    cond_e code;
    assign code = cond_e'(lvl_i[2*n +: 2]);
    always_comb begin
      unique case (code)
        COND_HIGH: ok[n] = sample_i[n];
        COND_LOW:  ok[n] = ~sample_i[n];
        default:   ok[n] = 1'b1;
      endcase
    end
  end

  assign match_o = &ok;
endmodule

// File: rtl/trig_edge_match.sv
module trig_edge_match
  import trig_match_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              valid_i,
  input  logic [NUM_CH-1:0] sample_i,
  input  logic [7:0]        edge_cfg_i,
  output logic              match_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]     prev_q;
  logic                  prev_vld_q;
  logic [EDGE_IDX_W-1:0] idx;
  logic                  in_range, cur_bit, prev_bit;
  edge_e                 kind;

  assign kind     = edge_e'(edge_cfg_i[7:6]);
  assign idx      = edge_cfg_i[EDGE_IDX_W-1:0];
  assign in_range = 32'(idx) < NUM_CH;
  assign cur_bit  = in_range ? sample_i[idx[CH_W-1:0]] : 1'b0;
  assign prev_bit = in_range ? prev_q[idx[CH_W-1:0]]   : 1'b0;

  always_comb begin
    unique case (kind)
      EDGE_NONE: match_o = 1'b1;
      EDGE_RISE: match_o = prev_vld_q && in_range && !prev_bit && cur_bit;
      EDGE_FALL: match_o = prev_vld_q && in_range && prev_bit && !cur_bit;
      default:   match_o = prev_vld_q && in_range && (prev_bit != cur_bit);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (arm_i) begin
      prev_vld_q <= 1'b0;
    end else if (valid_i) begin
      prev_q     <= sample_i;
      prev_vld_q <= 1'b1;
    end
  end

  // R6
  arm_clears_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !prev_vld_q);
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              arm_i,
  input  logic              sample_valid_i,
  input  logic [NUM_CH-1:0] sample_i,
  output logic              hit_o
);
  localparam int unsigned NUM_BYTES = NUM_CH / 4;

  logic [NUM_BYTES*8-1:0] lvl_cfg;
  logic [7:0]             edge_cfg;
  logic                   lvl_ok, edge_ok, hit_q;

  trig_cfg_bank #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .lvl_o(lvl_cfg), .edge_o(edge_cfg)
  );

  trig_level_match #(.NUM_CH(NUM_CH)) u_lvl (
    .lvl_i(lvl_cfg[2*NUM_CH-1:0]), .sample_i, .match_o(lvl_ok)
  );

  trig_edge_match #(.NUM_CH(NUM_CH)) u_edge (
    .clk_i, .rst_ni, .arm_i, .valid_i(sample_valid_i), .sample_i,
    .edge_cfg_i(edge_cfg), .match_o(edge_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= sample_valid_i && !arm_i && lvl_ok && edge_ok;
  end

  assign hit_o = hit_q;

  // R8
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(sample_valid_i));
  // R2
  hit_needs_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lvl_ok));
  // R10
  arm_blocks_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !hit_o);
endmodule

// File: tb/trig_matcher_test.sv
module trig_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        arm = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] sample = '0;
  logic        hit;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_matcher uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .arm_i(arm), .sample_valid_i(valid),
    .sample_i(sample), .hit_o(hit)
  );

  // {expected hit, sample}; cfg: ch0 high, ch5 low, ch31 code 3, rising on ch9
  localparam logic [32:0] VEC [0:8] = '{
    33'h0_0000_0201, 33'h0_0000_0001, 33'h1_0000_0201, 33'h0_0000_0001,
    33'h0_0000_0221, 33'h0_0000_0020, 33'h0_0000_0200, 33'h0_0000_0000,
    33'h1_8000_0201
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: hit_o=%b expected %b", req, hit, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic smp(input logic [31:0] s, input logic exp, input string req);
    valid = 1'b1; sample = s;
    @(negedge clk);
    valid = 1'b0;
    check(req, exp);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: hit_o=%b expected completion", hit);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", 1'b0);
    // R4 zero config triggers on any valid sample
    smp(32'h0, 1'b1, "R4 all-zero cfg");
    @(negedge clk);
    check("R8 no valid", 1'b0);
    // R9 unused address
    wr(4'd12, 8'hFF);
    wr(4'd9, 8'h55);
    smp(32'h0, 1'b1, "R9 unused addr");

    // table run: R2 R3 R4 R5 R6
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h08);
    wr(4'd7, 8'hC0);
    wr(4'd8, 8'h49);
    do_arm();
    for (int i = 0; i < 9; i++)
      smp(VEC[i][31:0], VEC[i][32], $sformatf("R2/R3/R5/R6 vec%0d", i));

    // falling then either edge on ch9, levels cleared
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h00);
    wr(4'd7, 8'h00);
    wr(4'd8, 8'h89);
    do_arm();
    smp(32'h200, 1'b0, "R6 first after arm");
    smp(32'h000, 1'b1, "R5 falling");
    smp(32'h200, 1'b0, "R5 rising on falling cfg");
    wr(4'd8, 8'hC9);
    smp(32'h000, 1'b1, "R5 either fall");
    smp(32'h200, 1'b1, "R5 either rise");
    smp(32'h200, 1'b0, "R5 either steady");

    // R7 index 33
    wr(4'd8, 8'hE1);
    do_arm();
    smp(32'h0, 1'b0, "R7 out of range");
    smp(32'hFFFF_FFFF, 1'b0, "R7 out of range");
    smp(32'h0, 1'b0, "R7 out of range");

    // R10 arm with valid, zero cfg
    wr(4'd8, 8'h00);
    arm = 1'b1; valid = 1'b1; sample = 32'h0;
    @(negedge clk);
    arm = 1'b0; valid = 1'b0;
    check("R10 arm+valid", 1'b0);
    smp(32'h0, 1'b1, "R10 after arm");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule